// File: doc/BRIEF.md
# Run-Time Configurable SPI Slave Port

This block is the slave end of a serial peripheral link. It watches the serial clock, the select line and the master-out data line, and drives the master-in data line. It exchanges characters with the host logic through parallel words. All three serial inputs are oversampled on a much faster system clock. Each one passes through a synchronizer before any edge is detected.

One 8-bit control register sets the behaviour at run time:

- clock idle level
- whether the sampling edge is the leading or the trailing edge of a clock pulse
- the active level of the select line
- a character length of 8 or 16 bits
- an enable for the arrival interrupt

The host loads a transmit word ahead of each character. It picks up each received character from a holding register, and reading that register clears the holding register's full flag. A character that lands while the previous one is still unread raises a sticky overrun flag.

Top module: `spi_slave_port`

## Requirements
- R1: After synchronous reset the control register reads 0x00, and `rx_full`, `rx_ovr`, `irq`, `rx_valid` and `miso` are all 0.
- R2: The control register uses these bits: bit 7 is the interrupt enable, bit 6 is the select polarity, bit 2 is the length (1 = 16 bits), bit 1 is the phase (1 = trailing-edge sampling) and bit 0 is the polarity (1 = clock idles high). Bits 5:3 always read 0, so writing 0xFF reads back 0xC7.
- R3: In all four polarity/phase combinations, MOSI is captured on the selected sampling edge, most significant bit first.
- R4: With bit 6 clear, the select line is active low. With bit 6 set, it is active high. Clock pulses while the select line is inactive receive nothing.
- R5: With bit 2 clear, a character is 8 bits. Only `tx_data[7:0]` is sent, and `rx_data[15:8]` reads 0. With bit 2 set, all 16 bits are exchanged.
- R6: MISO carries the transmit word most significant bit first and changes on the edge opposite the sampling edge. The first bit is present once select is active, before any clock edge. MISO is 0 while deselected.
- R7: Each completed character updates `rx_data`, sets `rx_full` and pulses `rx_valid` high for exactly one system clock.
- R8: A one-cycle `rx_rd` pulse clears `rx_full`. A character completing in the same cycle takes priority.
- R9: A character completing while `rx_full` is set overwrites `rx_data` and sets `rx_ovr`. Only reset clears `rx_ovr`.
- R10: `irq` is high exactly when the interrupt enable is set and `rx_full` is set. With the enable clear, `irq` stays 0.
- R11: Deselecting partway through a character discards the partial bits and resets the bit count. No `rx_valid` pulse occurs and `rx_full` does not change, and the next character is received whole.
- R12: Writes to the control register while select is active are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register contents |
| tx_load | input | 1 | Load `tx_data` into the transmit holding register |
| tx_data | input | DATA_W | Next character to send |
| rx_data | output | DATA_W | Last received character |
| rx_valid | output | 1 | One-cycle strobe when a character completes |
| rx_rd | input | 1 | Host read of `rx_data`; clears `rx_full` |
| rx_full | output | 1 | Unread character waiting |
| rx_ovr | output | 1 | Sticky overrun flag |
| irq | output | 1 | Gated character-arrival interrupt |
| sclk | input | 1 | Serial clock from the master |
| ssel | input | 1 | Select line from the master |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |

## Verification
The bench builds the block with its defaults: a 16-bit character width and two synchronizer stages. These reach both character lengths, including truncation of the upper byte in 8-bit mode. The serial clock runs at one sixteenth of the system clock. That leaves margin over the three-to-four-cycle path from a serial edge to a MISO update, so every polarity and phase combination can be checked bit-exactly in both directions.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

    // Control register image; bit order is the software-visible layout
    typedef struct packed {
        logic       irq_en;
        logic       sel_high;
        logic [2:0] rsvd;
        logic       len_wide;
        logic       late_phase;
        logic       idle_high;
    } spi_ctl_t;

    localparam logic [7:0] CTL_WRITABLE = 8'hC7;

    function automatic spi_ctl_t ctl_from_bus(input logic [7:0] raw);
        return spi_ctl_t'(raw & CTL_WRITABLE);
    endfunction

    // Select line level to "active" given the polarity choice
    function automatic logic sel_is_active(input logic line, input logic high_active);
        return high_active ? line : ~line;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_clk_edges.sv
module spi_clk_edges (
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic idle_high,
    input  logic late_phase,
    output logic sample_o,
    output logic shift_o
);
    logic prev;
    logic rise, fall, lead, trail;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= sclk_s;
    end

    always_comb begin
        rise     = sclk_s & ~prev;
        fall     = ~sclk_s & prev;
        lead     = idle_high ? fall : rise;
        trail    = idle_high ? rise : fall;
        sample_o = late_phase ? trail : lead;
        shift_o  = late_phase ? lead  : trail;
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              len_wide,
    input  logic              sample,
    input  logic              shift,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] tx_hold,
    output logic              miso_o,
    output logic              done_o,
    output logic [DATA_W-1:0] word_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int CNT_W  = $clog2(DATA_W);

    logic              active_q;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last_idx;
    logic [DATA_W-2:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] load_val;
    logic              at_last;
    logic              sel_start;

    always_comb begin
        last_idx  = len_wide ? CNT_W'(DATA_W - 1) : CNT_W'(HALF_W - 1);
        at_last   = (cnt == last_idx);
        sel_start = active & ~active_q;
        load_val  = len_wide ? tx_hold : {tx_hold[HALF_W-1:0], {HALF_W{1'b0}}};
        done_o    = active & sample & at_last;
        word_o    = len_wide ? {rx_sh[DATA_W-2:0], mosi_s}
                             : {{HALF_W{1'b0}}, rx_sh[HALF_W-2:0], mosi_s};
        miso_o    = active & tx_sh[DATA_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt      <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
        end else begin
            active_q <= active;
            if (!active) begin
                cnt   <= '0;
                rx_sh <= '0;
            end else if (sample) begin
                rx_sh <= {rx_sh[DATA_W-3:0], mosi_s};
                cnt   <= at_last ? '0 : cnt + 1'b1;
            end

            if (sel_start) begin
                tx_sh <= load_val;
            end else if (active && sample && at_last) begin
                tx_sh <= load_val;
            end else if (active && shift && cnt != '0) begin
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/spi_slave_port.sv
module spi_slave_port
    import spi_slave_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_rd,
    output logic              rx_full,
    output logic              rx_ovr,
    output logic              irq,
    input  logic              sclk,
    input  logic              ssel,
    input  logic              mosi,
    output logic              miso
);
    // sync bit order: {sclk, ssel, mosi}; select idles high for the reset polarity
    localparam logic [2:0] SYNC_RST = 3'b010;

    spi_ctl_t          ctl_q, ctl_nxt;
    logic [2:0]        pins_s;
    logic              sclk_s, ssel_s, mosi_s;
    logic              sel_active;
    logic              sample, shift, done;
    logic [DATA_W-1:0] word, tx_hold;
    logic              full_nxt;

    spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst(rst), .d({sclk, ssel, mosi}), .q(pins_s)
    );

    assign {sclk_s, ssel_s, mosi_s} = pins_s;
    assign sel_active = sel_is_active(ssel_s, ctl_q.sel_high);

    spi_clk_edges u_edges (
        .clk(clk), .rst(rst), .sclk_s(sclk_s),
        .idle_high(ctl_q.idle_high), .late_phase(ctl_q.late_phase),
        .sample_o(sample), .shift_o(shift)
    );

    spi_shift_engine #(.DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst(rst), .active(sel_active), .len_wide(ctl_q.len_wide),
        .sample(sample), .shift(shift), .mosi_s(mosi_s), .tx_hold(tx_hold),
        .miso_o(miso), .done_o(done), .word_o(word)
    );

    always_comb begin
        ctl_nxt  = (cfg_wr && !sel_active) ? ctl_from_bus(cfg_wdata) : ctl_q;
        full_nxt = done ? 1'b1 : (rx_rd ? 1'b0 : rx_full);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            tx_hold  <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_full  <= 1'b0;
            rx_ovr   <= 1'b0;
            irq      <= 1'b0;
        end else begin
            ctl_q    <= ctl_nxt;
            rx_valid <= done;
            rx_full  <= full_nxt;
            irq      <= ctl_nxt.irq_en & full_nxt;
            if (tx_load) tx_hold <= tx_data;
            if (done) begin
                rx_data <= word;
                if (rx_full) rx_ovr <= 1'b1;
            end
        end
    end

    assign cfg_rdata = ctl_q;
endmodule

// File: rtl/spi_slave_port_chk.sv
module spi_slave_port_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        cfg_rdata,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_rd,
    input logic              rx_full,
    input logic              rx_ovr,
    input logic              irq,
    input logic              sel_active,
    input logic              miso
);
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[5:3] == 3'b000);

    assert_narrow_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !cfg_rdata[2]) |-> rx_data[DATA_W-1:DATA_W/2] == '0);

    assert_miso_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !sel_active |-> !miso);

    assert_valid_sets_full_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> rx_full);

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        rx_rd |=> (!rx_full || rx_valid));

    assert_ovr_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ovr) |-> (rx_valid && $past(rx_full)));

    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        rx_ovr |=> rx_ovr);

    assert_irq_needs_full_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> rx_full);

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[7] |-> !irq);

    assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        sel_active |=> $stable(cfg_rdata));
endmodule

bind spi_slave_port spi_slave_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_rd(rx_rd), .rx_full(rx_full), .rx_ovr(rx_ovr),
    .irq(irq), .sel_active(sel_active), .miso(miso)
);

// File: tb/spi_slave_port_tb.sv
module spi_slave_port_tb;
    localparam int H    = 8;
    localparam int NVEC = 9;

    // {cfg[71:64], tx[63:48], mosi word[47:32], expected rx[31:16], expected miso word[15:0]}
    localparam logic [71:0] VEC [NVEC] = '{
        {8'h00, 16'h00A5, 16'h003C, 16'h003C, 16'h00A5},
        {8'h01, 16'h005A, 16'h00C3, 16'h00C3, 16'h005A},
        {8'h02, 16'h0081, 16'h007E, 16'h007E, 16'h0081},
        {8'h03, 16'h0017, 16'h00E8, 16'h00E8, 16'h0017},
        {8'h84, 16'hBEEF, 16'h1234, 16'h1234, 16'hBEEF},
        {8'h87, 16'hC0DE, 16'hF00D, 16'hF00D, 16'hC0DE},
        {8'h40, 16'h0066, 16'h0099, 16'h0099, 16'h0066},
        {8'hC6, 16'h8001, 16'h7FFE, 16'h7FFE, 16'h8001},
        {8'h00, 16'hAB12, 16'h56CD, 16'h00CD, 16'h0012}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        tx_load = 1'b0;
    logic [15:0] tx_data = '0;
    logic [15:0] rx_data;
    logic        rx_valid, rx_full, rx_ovr, irq, miso;
    logic        rx_rd = 1'b0;
    logic        sclk = 1'b0, ssel = 1'b1, mosi = 1'b0;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) if (!rst && rx_valid) pulses <= pulses + 1;

    spi_slave_port u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tx_load(tx_load), .tx_data(tx_data),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_rd(rx_rd),
        .rx_full(rx_full), .rx_ovr(rx_ovr), .irq(irq),
        .sclk(sclk), .ssel(ssel), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic load_tx(input logic [15:0] v);
        @(negedge clk); tx_load = 1'b1; tx_data = v;
        @(negedge clk); tx_load = 1'b0;
    endtask

    task automatic read_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic spi_xfer(input logic cpol, input logic cpha, input logic sel_hi,
                            input int nbits, input logic [15:0] mo,
                            output logic [15:0] mi);
        mi = '0;
        @(negedge clk); sclk = cpol; ssel = ~sel_hi;
        wait_clk(H);
        ssel = sel_hi;
        wait_clk(H);
        for (int i = nbits - 1; i >= 0; i--) begin
            if (!cpha) begin
                mosi = mo[i];
                wait_clk(H);
                mi = {mi[14:0], miso};
                sclk = ~cpol;
                wait_clk(H);
                sclk = cpol;
            end else begin
                sclk = ~cpol;
                mosi = mo[i];
                wait_clk(H);
                mi = {mi[14:0], miso};
                sclk = cpol;
                wait_clk(H);
            end
        end
        wait_clk(H);
        ssel = ~sel_hi;
        wait_clk(8);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] got;
        int          p0;

        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R1 reset state
        chk("R1 cfg", cfg_rdata, 8'h00);
        chk("R1 flags", {rx_full, rx_ovr, irq, rx_valid}, 4'b0000);
        chk("R1 miso", miso, 1'b0);

        // R2 reserved bits masked
        write_cfg(8'hFF);
        chk("R2 readback", cfg_rdata, 8'hC7);
        ssel = 1'b0;
        wait_clk(6);
        write_cfg(8'h00);
        chk("R2 clear", cfg_rdata, 8'h00);
        ssel = 1'b1;
        wait_clk(6);

        // R3 R4 R5 R6 R7 R8 R10: vector walk
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0]  c;
            int          nb;
            c  = VEC[v][71:64];
            nb = c[2] ? 16 : 8;
            write_cfg(c);
            load_tx(VEC[v][63:48]);
            p0 = pulses;
            spi_xfer(c[0], c[1], c[6], nb, VEC[v][47:32], got);
            chk("R3/R5 rx_data", rx_data, VEC[v][31:16]);
            chk("R6 miso word", got, VEC[v][15:0]);
            chk("R6 miso idle", miso, 1'b0);
            chk("R7 full", rx_full, 1'b1);
            chk("R7 one strobe", pulses - p0, 1);
            chk("R10 irq", irq, c[7]);
            read_rx();
            chk("R8 cleared", {rx_full, irq}, 2'b00);
        end

        // R12 write during active select dropped
        ssel = 1'b0;
        wait_clk(6);
        write_cfg(8'h87);
        chk("R12 ignored", cfg_rdata, 8'h00);
        ssel = 1'b1;
        wait_clk(6);
        write_cfg(8'h80);
        chk("R12 accepted", cfg_rdata, 8'h80);

        // R11 aborted character
        load_tx(16'h0000);
        p0 = pulses;
        spi_xfer(1'b0, 1'b0, 1'b0, 3, 16'h0007, got);
        chk("R11 no strobe", pulses - p0, 0);
        chk("R11 no full/irq", {rx_full, irq}, 2'b00);
        spi_xfer(1'b0, 1'b0, 1'b0, 8, 16'h005A, got);
        chk("R11 next whole", rx_data, 16'h005A);
        chk("R10 irq on", irq, 1'b1);
        read_rx();

        // R4 clocks with select inactive (active-high mode, line low)
        write_cfg(8'h40);
        ssel = 1'b0; mosi = 1'b1;
        wait_clk(6);
        p0 = pulses;
        for (int k = 0; k < 16; k++) begin
            sclk = 1'b1; wait_clk(H);
            sclk = 1'b0; wait_clk(H);
        end
        chk("R4 inactive ignored", {rx_full, 8'(pulses - p0)}, 9'h000);

        // R9 overrun
        write_cfg(8'h80);
        spi_xfer(1'b0, 1'b0, 1'b0, 8, 16'h0011, got);
        chk("R9 no ovr yet", rx_ovr, 1'b0);
        spi_xfer(1'b0, 1'b0, 1'b0, 8, 16'h0022, got);
        chk("R9 ovr set", rx_ovr, 1'b1);
        chk("R9 overwrite", rx_data, 16'h0022);
        read_rx();
        chk("R9 sticky", {rx_ovr, rx_full, irq}, 3'b100);

        finish_run();
    end
endmodule